// File: doc/BRIEF.md
# Device Register Space Decoder

This block sits behind a host register port and splits one power-of-two register aperture into four sub-regions: a capability array, a device-status region, a mailbox region and a memory-device status region. The aperture size is the end of the last sub-region rounded up to the next power of two, and the request address width follows from it. Each request gives a byte address, a size code and, for writes, data. The block answers every request with a one-cycle registered response.

The capability array describes itself. A header word gives the array's own ID, its version and the number of capabilities. One two-word entry per capability follows, with that capability's ID, version, sub-region offset and sub-region length, so software can find every region without fixed knowledge. All entry contents come from parameters. The device-status region reads as zero. The memory-device region reads as a single constant status word. Writes to these three regions have no effect. Mailbox accesses are passed through on a separate mailbox port in the request cycle, and the mailbox's read data is returned unchanged.

Every read from a non-mailbox region is cut from the 64-bit word that holds the addressed bytes. Accesses that are not naturally aligned return zero and are never forwarded. Every sub-region is a power of two long and starts at a multiple of its own length.

Top module: `regspace_decoder`

## Requirements
- R1: rsp_valid is 0 during reset. Every request cycle (req_valid high) produces rsp_valid high in the next cycle, and a cycle without a request produces none. A write's response carries rsp_rdata equal to 0.
- R2: The capability header is the 64-bit word at aperture offset 0x000. Bits [15:0] hold ID 0, bits [23:16] hold version 1, bits [47:32] hold count 3, and all other bits are 0.
- R3: Capability entry i (i = 0, 1, 2) occupies the words at offsets 0x10+16*i and 0x18+16*i. The first word holds the ID in bits [15:0] and version 1 in bits [23:16]. The second word holds the sub-region offset in bits [31:0] and its length in bits [63:32]. The entries appear in this order: device status (ID 1, 0x080, 0x20), mailbox (ID 2, 0x100, 0x100), memory device (ID 0x4000, 0x200, 0x8). The rest of the array (0x000 to 0x07F) reads as 0.
- R4: Every read in the device-status region (0x080 to 0x09F) returns 0.
- R5: The memory-device word at 0x200 reads as 0x11: media-status field bits [1:0] = 1, mailbox-ready bit 4 = 1, all other bits 0.
- R6: Writes to the capability, device-status and memory-device regions are not forwarded (mb_valid stays low), and later reads return the same values as before the write.
- R7: Size code 0, 1, 2, 3 selects 1, 2, 4 or 8 bytes. A non-mailbox read returns the selected bytes of the enclosing 8-byte word, starting at address bits [2:0], right-aligned, with the upper bits zero (little-endian).
- R8: An aligned access in the mailbox region (0x100 to 0x1FF) raises mb_valid in the same cycle. mb_write, mb_size and mb_wdata copy the request, and mb_addr equals the address minus 0x100. A mailbox read returns mb_rdata as it was in the request cycle.
- R9: An access that falls in no sub-region (including 0x0A0 to 0x0FF and 0x208 to 0x3FF) reads 0 and is not forwarded.
- R10: An access whose address is not a multiple of its size reads 0 and is not forwarded, even inside the mailbox region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (10) | Byte address within the aperture |
| req_size | input | 2 | Size code: 1, 2, 4 or 8 bytes |
| req_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Read data, right-aligned |
| mb_valid | output | 1 | Mailbox access this cycle |
| mb_write | output | 1 | Mailbox access is a write |
| mb_addr | output | MBOX_AW (8) | Byte offset within the mailbox region |
| mb_size | output | 2 | Mailbox access size code |
| mb_wdata | output | 64 | Mailbox write data |
| mb_rdata | input | 64 | Mailbox read data, valid in the same cycle |

## Verification
The hardest case to reach is a sub-word or misaligned access that lands on a region edge or inside the mailbox. There, correct behaviour depends on the alignment check, the region match and the byte-lane selection all agreeing. The stimulus walks every capability word back to back. It then sends 1-, 2- and 4-byte reads at offsets inside the header and entry words, and misaligned reads and writes at mailbox and capability addresses. Probes at the last byte of each region and of the aperture exercise the boundaries. Writes of all-ones to every read-only region are each followed by a read of the same word.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

  localparam int unsigned WORD_W = 64;
  localparam int unsigned N_REGIONS = 4;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } size_e;

  // Region slots in the hit vector
  localparam int unsigned RG_CAP  = 0;
  localparam int unsigned RG_DEV  = 1;
  localparam int unsigned RG_MBOX = 2;
  localparam int unsigned RG_MDEV = 3;

  function automatic int unsigned pow2_ceil(input int unsigned v);
    int unsigned p;
    p = 1;
    while (p < v) p = p << 1;
    return p;
  endfunction

endpackage

// File: rtl/rs_reset_sync.sv
module rs_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rs_region_decode.sv
module rs_region_decode #(
  parameter int unsigned AW       = 10,
  parameter int unsigned CAP_OFS  = 'h000,
  parameter int unsigned CAP_LEN  = 'h080,
  parameter int unsigned DEV_OFS  = 'h080,
  parameter int unsigned DEV_LEN  = 'h020,
  parameter int unsigned MBOX_OFS = 'h100,
  parameter int unsigned MBOX_LEN = 'h100,
  parameter int unsigned MDEV_OFS = 'h200,
  parameter int unsigned MDEV_LEN = 'h008
) (
  input  logic [AW-1:0]                   addr,
  input  logic [1:0]                      size,
  output logic [rsd_pkg::N_REGIONS-1:0]   hit,
  output logic                            misaligned
);
  import rsd_pkg::*;

  localparam int unsigned R_OFS [N_REGIONS] = '{CAP_OFS, DEV_OFS, MBOX_OFS, MDEV_OFS};
  localparam int unsigned R_LEN [N_REGIONS] = '{CAP_LEN, DEV_LEN, MBOX_LEN, MDEV_LEN};

  // Each region is a power of two long and aligned to its length,
  // so a match is a compare of the upper address bits only.
  for (genvar g = 0; g < N_REGIONS; g++) begin : g_rgn
    localparam int unsigned RB = $clog2(R_LEN[g]);
    localparam logic [AW-1:0] BASE_V = AW'(R_OFS[g]);
    assign hit[g] = (addr[AW-1:RB] == BASE_V[AW-1:RB]);
  end

  logic [2:0] low_mask;
  always_comb begin
    unique case (size_e'(size))
      SZ_B1:   low_mask = 3'b000;
      SZ_B2:   low_mask = 3'b001;
      SZ_B4:   low_mask = 3'b011;
      default: low_mask = 3'b111;
    endcase
  end

  assign misaligned = |(addr[2:0] & low_mask);
endmodule

// File: rtl/rs_cap_rom.sv
module rs_cap_rom #(
  parameter int unsigned N_CAPS    = 3,
  parameter int unsigned IDX_W     = 4,
  parameter logic [15:0] ARR_ID    = 16'h0000,
  parameter logic [7:0]  ARR_VER   = 8'd1,
  parameter logic [7:0]  ENT_VER   = 8'd1,
  parameter logic [N_CAPS*16-1:0] ENT_IDS  = '0,
  parameter logic [N_CAPS*32-1:0] ENT_OFS  = '0,
  parameter logic [N_CAPS*32-1:0] ENT_LENS = '0
) (
  input  logic [IDX_W-1:0] idx,
  output logic [63:0]      word
);
  localparam logic [63:0] HDR_WORD =
    {16'h0000, 16'(N_CAPS), 8'h00, ARR_VER, ARR_ID};

  logic [63:0] id_word  [N_CAPS];
  logic [63:0] loc_word [N_CAPS];

  for (genvar i = 0; i < N_CAPS; i++) begin : g_ent
    assign id_word[i]  = {40'h0, ENT_VER, ENT_IDS[i*16 +: 16]};
    assign loc_word[i] = {ENT_LENS[i*32 +: 32], ENT_OFS[i*32 +: 32]};
  end

  always_comb begin
    word = '0;
    if (idx == '0) word = HDR_WORD;
    for (int i = 0; i < N_CAPS; i++) begin
      if (idx == IDX_W'(2 + 2*i)) word = id_word[i];
      if (idx == IDX_W'(3 + 2*i)) word = loc_word[i];
    end
  end
endmodule

// File: rtl/rs_lane_extract.sv
module rs_lane_extract (
  input  logic [63:0] word,
  input  logic [2:0]  byte_ofs,
  input  logic [1:0]  size,
  output logic [63:0] data
);
  import rsd_pkg::*;

  logic [63:0] shifted;
  assign shifted = word >> {byte_ofs, 3'b000};

  always_comb begin
    unique case (size_e'(size))
      SZ_B1:   data = {56'h0, shifted[7:0]};
      SZ_B2:   data = {48'h0, shifted[15:0]};
      SZ_B4:   data = {32'h0, shifted[31:0]};
      default: data = shifted;
    endcase
  end
endmodule

// File: rtl/regspace_decoder.sv
module regspace_decoder #(
  parameter int unsigned CAP_OFS     = 'h000,
  parameter int unsigned CAP_LEN     = 'h080,
  parameter int unsigned DEV_OFS     = 'h080,
  parameter int unsigned DEV_LEN     = 'h020,
  parameter int unsigned MBOX_OFS    = 'h100,
  parameter int unsigned MBOX_LEN    = 'h100,
  parameter int unsigned MDEV_OFS    = 'h200,
  parameter int unsigned MDEV_LEN    = 'h008,
  parameter logic [15:0] DEV_CAP_ID  = 16'h0001,
  parameter logic [15:0] MBOX_CAP_ID = 16'h0002,
  parameter logic [15:0] MDEV_CAP_ID = 16'h4000,
  parameter logic [1:0]  MEDIA_STATE = 2'd1,
  parameter int unsigned MB_RDY_BIT  = 4,
  // Derived: keep at defaults
  parameter int unsigned AW      = $clog2(rsd_pkg::pow2_ceil(MDEV_OFS + MDEV_LEN)),
  parameter int unsigned MBOX_AW = $clog2(MBOX_LEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [AW-1:0]      req_addr,
  input  logic [1:0]         req_size,
  input  logic [63:0]        req_wdata,
  output logic               rsp_valid,
  output logic [63:0]        rsp_rdata,
  output logic               mb_valid,
  output logic               mb_write,
  output logic [MBOX_AW-1:0] mb_addr,
  output logic [1:0]         mb_size,
  output logic [63:0]        mb_wdata,
  input  logic [63:0]        mb_rdata
);
  import rsd_pkg::*;

  localparam int unsigned N_CAPS   = 3;
  localparam int unsigned CAP_AW   = $clog2(CAP_LEN);
  localparam int unsigned CAP_IDXW = CAP_AW - 3;
  localparam logic [63:0] MDEV_WORD =
    (64'(MEDIA_STATE)) | (64'd1 << MB_RDY_BIT);

  localparam logic [N_CAPS*16-1:0] ENT_IDS  = {MDEV_CAP_ID, MBOX_CAP_ID, DEV_CAP_ID};
  localparam logic [N_CAPS*32-1:0] ENT_OFS  = {32'(MDEV_OFS), 32'(MBOX_OFS), 32'(DEV_OFS)};
  localparam logic [N_CAPS*32-1:0] ENT_LENS = {32'(MDEV_LEN), 32'(MBOX_LEN), 32'(DEV_LEN)};

  // Reset release synchronised to clk
  logic rst_n_i;
  rs_reset_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  // Address decode
  logic [N_REGIONS-1:0] hit;
  logic                 misaligned;

  rs_region_decode #(
    .AW(AW),
    .CAP_OFS(CAP_OFS),   .CAP_LEN(CAP_LEN),
    .DEV_OFS(DEV_OFS),   .DEV_LEN(DEV_LEN),
    .MBOX_OFS(MBOX_OFS), .MBOX_LEN(MBOX_LEN),
    .MDEV_OFS(MDEV_OFS), .MDEV_LEN(MDEV_LEN)
  ) u_dec (
    .addr(req_addr), .size(req_size), .hit(hit), .misaligned(misaligned)
  );

  // Capability words
  logic [63:0] cap_word;
  rs_cap_rom #(
    .N_CAPS(N_CAPS), .IDX_W(CAP_IDXW),
    .ARR_ID(16'h0000), .ARR_VER(8'd1), .ENT_VER(8'd1),
    .ENT_IDS(ENT_IDS), .ENT_OFS(ENT_OFS), .ENT_LENS(ENT_LENS)
  ) u_rom (
    .idx(req_addr[CAP_AW-1:3]), .word(cap_word)
  );

  // Source word for read-only regions
  logic [63:0] src_word;
  always_comb begin
    src_word = '0;
    if (hit[RG_CAP])  src_word = cap_word;
    if (hit[RG_DEV])  src_word = '0;
    if (hit[RG_MDEV]) src_word = MDEV_WORD;
  end

  logic [63:0] lane_data;
  rs_lane_extract u_lane (
    .word(src_word), .byte_ofs(req_addr[2:0]), .size(req_size), .data(lane_data)
  );

  // Mailbox pass-through
  logic mb_sel;
  assign mb_sel   = hit[RG_MBOX] && !misaligned;
  assign mb_valid = req_valid && mb_sel;
  assign mb_write = req_write;
  assign mb_addr  = req_addr[MBOX_AW-1:0];
  assign mb_size  = req_size;
  assign mb_wdata = req_wdata;

  // Response: next-state
  logic        rsp_valid_q, rsp_valid_d;
  logic [63:0] rsp_rdata_q, rsp_rdata_d;
  logic        rsp_en;

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_en      = req_valid;
    if (req_write || misaligned) rsp_rdata_d = '0;
    else if (hit[RG_MBOX])       rsp_rdata_d = mb_rdata;
    else                         rsp_rdata_d = lane_data;
  end

  // Response: registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      if (rsp_en) rsp_rdata_q <= rsp_rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/regspace_decoder_chk.sv
module regspace_decoder_chk #(
  parameter int unsigned AW       = 10,
  parameter int unsigned MBOX_AW  = 8,
  parameter int unsigned MBOX_OFS = 'h100,
  parameter int unsigned DEV_OFS  = 'h080,
  parameter int unsigned DEV_LEN  = 'h020,
  parameter int unsigned MDEV_OFS = 'h200
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [AW-1:0]      req_addr,
  input logic [1:0]         req_size,
  input logic               rsp_valid,
  input logic [63:0]        rsp_rdata,
  input logic               mb_valid,
  input logic [MBOX_AW-1:0] mb_addr
);
  localparam logic [AW-1:0] MB_BASE  = AW'(MBOX_OFS);
  localparam logic [AW-1:0] MDEV_A   = AW'(MDEV_OFS);
  localparam int unsigned   DEV_B    = $clog2(DEV_LEN);
  localparam logic [AW-1:0] DEV_BASE = AW'(DEV_OFS);

  logic [3:0] nbytes;
  logic       bad_align;
  logic       in_mbox;
  logic       in_dev;
  assign nbytes    = 4'd1 << req_size;
  assign bad_align = (({1'b0, req_addr[2:0]} % nbytes) != 4'd0);
  assign in_mbox   = (req_addr[AW-1:MBOX_AW] == MB_BASE[AW-1:MBOX_AW]);
  assign in_dev    = (req_addr[AW-1:DEV_B] == DEV_BASE[AW-1:DEV_B]);

  // R1
  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_write_rsp_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == 64'h0));
  // R4
  p_dev_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && in_dev) |=> (rsp_rdata == 64'h0));
  // R5
  p_mdev_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == MDEV_A && req_size == 2'd3)
      |=> (rsp_rdata == 64'h11));
  // R7
  p_byte_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 2'd0 && !in_mbox)
      |=> (rsp_rdata[63:8] == 56'h0));
  // R8
  p_mb_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mb_valid |-> (req_valid && in_mbox));
  p_mb_addr_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mb_valid |-> (mb_addr == MBOX_AW'(req_addr - MB_BASE)));
  // R10
  p_misaligned_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bad_align) |-> !mb_valid);
  p_misaligned_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bad_align) |=> (rsp_rdata == 64'h0));
endmodule

bind regspace_decoder regspace_decoder_chk #(
  .AW(AW), .MBOX_AW(MBOX_AW), .MBOX_OFS(MBOX_OFS),
  .DEV_OFS(DEV_OFS), .DEV_LEN(DEV_LEN), .MDEV_OFS(MDEV_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .mb_valid(mb_valid), .mb_addr(mb_addr)
);

// File: tb/regspace_decoder_tb.sv
`timescale 1ns/1ps
module regspace_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        mb_valid, mb_write;
  logic [7:0]  mb_addr;
  logic [1:0]  mb_size;
  logic [63:0] mb_wdata;
  logic [63:0] mb_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  // Mailbox stand-in: data depends on the offset it is given
  assign mb_rdata = {56'h5A5A5A5A5A5A5A, mb_addr};

  regspace_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mb_valid(mb_valid), .mb_write(mb_write), .mb_addr(mb_addr),
    .mb_size(mb_size), .mb_wdata(mb_wdata), .mb_rdata(mb_rdata)
  );

  // ---------------- reference model ----------------
  function automatic logic [63:0] ref_cap(input int idx);
    case (idx)
      0: return 64'h0000_0003_0001_0000;       // R2
      2: return 64'h0000_0000_0001_0001;       // R3 entry 0
      3: return 64'h0000_0020_0000_0080;
      4: return 64'h0000_0000_0001_0002;
      5: return 64'h0000_0100_0000_0100;
      6: return 64'h0000_0000_0001_4000;
      7: return 64'h0000_0008_0000_0200;
      default: return 64'h0;
    endcase
  endfunction

  function automatic bit ref_fwd(input int a, input int sz);
    int nb = 1 << sz;
    return (a >= 'h100) && (a < 'h200) && ((a % nb) == 0);
  endfunction

  function automatic logic [63:0] ref_data(input bit w, input int a, input int sz);
    int nb = 1 << sz;
    logic [63:0] word;
    logic [63:0] r;
    if (w) return 64'h0;
    if ((a % nb) != 0) return 64'h0;
    if (a >= 'h100 && a < 'h200) return {56'h5A5A5A5A5A5A5A, 8'(a - 'h100)};
    if (a < 'h80) word = ref_cap(a / 8);
    else if (a >= 'h200 && a < 'h208) word = 64'h11;
    else word = 64'h0;
    r = word >> (8 * (a % 8));
    if (nb < 8) r = r & ((64'h1 << (8 * nb)) - 64'h1);
    return r;
  endfunction

  logic        exp_v;
  logic [63:0] exp_d;
  string       exp_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_v <= 1'b0;
    end else begin
      exp_v <= req_valid;
      if (req_valid) begin
        exp_d   <= ref_data(req_write, int'(req_addr), int'(req_size));
        exp_tag <= cur_tag;
      end
    end
  end

  string cur_tag = "R1";

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    n_tests++;
    if (rsp_valid !== exp_v) begin
      n_fail++;
      $display("FAIL R1 rsp_valid actual=%0b expected=%0b", rsp_valid, exp_v);
    end else if (exp_v) begin
      n_tests++;
      if (rsp_rdata !== exp_d) begin
        n_fail++;
        $display("FAIL %s rsp_rdata actual=%h expected=%h", exp_tag, rsp_rdata, exp_d);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input bit w, input int a, input int sz, input logic [63:0] d,
                      input string tag);
    bit fwd;
    @(negedge clk);
    cur_tag   = tag;
    req_valid = 1'b1;
    req_write = w;
    req_addr  = 10'(a);
    req_size  = 2'(sz);
    req_wdata = d;
    #1;
    fwd = ref_fwd(a, sz);
    n_tests++;
    if (mb_valid !== fwd) begin
      n_fail++;
      $display("FAIL %s mb_valid addr=%h actual=%0b expected=%0b", tag, a, mb_valid, fwd);
    end else if (fwd) begin
      n_tests++;
      if (mb_addr !== 8'(a - 'h100) || mb_write !== w || mb_size !== 2'(sz) ||
          mb_wdata !== d) begin
        n_fail++;
        $display("FAIL %s mb fields actual=%h/%0b/%0d/%h expected=%h/%0b/%0d/%h", tag,
                 mb_addr, mb_write, mb_size, mb_wdata, 8'(a - 'h100), w, sz, d);
      end
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    // R1: reset state observed by the per-clock compare
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: header, whole and carved
    send(0, 'h000, 3, '0, "R2");
    send(0, 'h000, 2, '0, "R2");
    send(0, 'h004, 2, '0, "R2");
    send(0, 'h002, 1, '0, "R2");
    send(0, 'h002, 0, '0, "R2");
    idle(2);

    // R3: every capability word back to back
    for (int i = 0; i < 16; i++) send(0, i * 8, 3, '0, "R3");
    send(0, 'h010, 1, '0, "R3");
    send(0, 'h030, 1, '0, "R3");
    send(0, 'h03C, 2, '0, "R3");
    send(0, 'h028, 2, '0, "R3");
    idle(3);

    // R4: device status
    send(0, 'h080, 3, '0, "R4");
    send(0, 'h09C, 2, '0, "R4");
    send(0, 'h09F, 0, '0, "R4");

    // R5: memory device word
    send(0, 'h200, 3, '0, "R5");
    send(0, 'h200, 0, '0, "R5");
    send(0, 'h204, 2, '0, "R5");

    // R7: lane selection across sizes
    send(0, 'h018, 0, '0, "R7");
    send(0, 'h019, 0, '0, "R7");
    send(0, 'h01C, 1, '0, "R7");
    send(0, 'h038, 2, '0, "R7");
    idle(1);

    // R6: writes to read-only regions, then re-read
    send(1, 'h010, 3, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
    send(1, 'h000, 2, 64'hFFFF_FFFF, "R6");
    send(1, 'h080, 3, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
    send(1, 'h200, 3, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
    send(0, 'h010, 3, '0, "R6");
    send(0, 'h000, 3, '0, "R6");
    send(0, 'h080, 3, '0, "R6");
    send(0, 'h200, 3, '0, "R6");
    idle(2);

    // R8: mailbox pass-through
    send(0, 'h100, 3, '0, "R8");
    send(0, 'h1F8, 3, '0, "R8");
    send(0, 'h104, 2, '0, "R8");
    send(1, 'h108, 3, 64'h0123_4567_89AB_CDEF, "R8");
    send(0, 'h1FF, 0, '0, "R8");
    send(1, 'h1F0, 1, 64'hBEEF, "R8");
    idle(2);

    // R9: holes and the top of the aperture
    send(0, 'h0A0, 3, '0, "R9");
    send(0, 'h0F8, 3, '0, "R9");
    send(0, 'h208, 3, '0, "R9");
    send(0, 'h3F8, 3, '0, "R9");
    send(0, 'h3FF, 0, '0, "R9");
    send(1, 'h300, 3, 64'h1, "R9");
    idle(1);

    // R10: misaligned accesses
    send(0, 'h004, 3, '0, "R10");
    send(0, 'h011, 1, '0, "R10");
    send(0, 'h102, 2, '0, "R10");
    send(1, 'h101, 1, 64'h55, "R10");
    send(0, 'h1FC, 3, '0, "R10");
    send(0, 'h202, 2, '0, "R10");
    idle(4);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule